// File: doc/BRIEF.md
# Two-Stage Register-Move Pipeline Core

This core executes a four-instruction subset of a 64-bit teaching instruction set: stop, no-operation, load of an immediate into a register, and copy of one register into another. Work is split over two clock stages. The first stage fetches an instruction from a small byte-addressed instruction store and decodes it. The second stage writes the result into a fifteen-entry register file. A single pipeline register joins the two stages and carries the opcode, immediate, operand value, destination id and status. Its reset and empty state is a no-operation that targets no register.

When a copy reads a register that the instruction ahead of it is writing in the same cycle, the value on its way into the register file is steered straight into the operand. Back-to-back dependent moves therefore run at one instruction per cycle with no stall. A stop instruction, an unknown opcode or a fetch past the end of the store freezes the program counter at that instruction. The matching status code appears, and the core reports itself halted once that instruction reaches the second stage. A test environment loads the store through a byte write port while the core is held in reset. It watches the register-file write port, the program counter and the status.

Top module: `mv_pipe2_core`

## Requirements
- R1: While rst_n is low, and for two rising edges after it goes high, pc_o is 0, stat_o is 1 (running), halted is 0 and wb_en is 0. The first instruction is decoded in the cycle that ends at the third rising edge after release, and all fifteen registers start at zero.
- R2: Opcode byte 0x30 is a 10-byte immediate load. The second byte holds an ignored high nibble and the destination id in its low nibble, and the next eight bytes are the value, least significant byte first. It appears on wb_en/wb_dst/wb_data in the cycle after it is decoded.
- R3: Opcode byte 0x20 is a 2-byte copy. Its second byte holds the source id in the high nibble and the destination id in the low nibble. A source id of 0xF reads as zero.
- R4: A copy that reads the register written by the instruction just ahead of it receives the new value with no stall. The program "load 1 into id 0; copy id 0 to id 3; stop" shows halted in its 4th cycle, with both registers equal to 1.
- R5: The program "load 0x162e into id 0; load 0x22 into id 1; copy id 0 to id 2; copy id 1 to id 0; stop" shows halted in its 6th cycle. It ends with id 0 = 0x22, id 1 = 0x22, id 2 = 0x162e and pc_o = 0x18.
- R6: While running, pc_o advances each cycle by the length of the decoded instruction: 1 for 0x10 (no-operation), 2 for 0x20 and 10 for 0x30.
- R7: Opcode byte 0x00 stops the core. pc_o stays at its address, stat_o becomes 2 and halted rises one cycle after it is decoded, and no register write follows.
- R8: Any other opcode byte gives stat_o = 4 and halts in the same way. Neither that instruction nor any instruction after it writes a register.
- R9: An instruction whose bytes run past the last address of the instruction store gives stat_o = 3 and halts with pc_o at its first byte.
- R10: A destination id of 0xF performs no write: wb_en stays low while that instruction is in writeback.
- R11: Once halted is high, stat_o, pc_o and halted hold their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two synchronizing stages |
| imem_we | input | 1 | Instruction store byte write enable |
| imem_waddr | input | 6 | Instruction store byte address |
| imem_wdata | input | 8 | Instruction store byte data |
| pc_o | output | 64 | Address of the instruction in fetch/decode |
| wb_en | output | 1 | Register-file write in this cycle |
| wb_dst | output | 4 | Register id written |
| wb_data | output | 64 | Value written |
| stat_o | output | 3 | Status of the instruction in writeback: 1 running, 2 stopped, 3 bad address, 4 bad opcode |
| halted | output | 1 | High when stat_o is not 1 |

## Verification
The hardest case to reach from the ports is a fetch that runs off the end of the instruction store. A program has to be long enough to place a multi-byte instruction across the last address, so the bench fills the store with sixty one-byte no-operations and then a single immediate-load opcode. Chains of copies that each read the register written one cycle earlier drive the bypass path on every cycle. A source id of 0xF follows a nonzero load into the same destination, so a zero read is seen as a change in the written value.

// File: rtl/mvp_pkg.sv
package mvp_pkg;
  localparam logic [7:0] OP_STOP  = 8'h00;
  localparam logic [7:0] OP_NOP   = 8'h10;
  localparam logic [7:0] OP_COPY  = 8'h20;
  localparam logic [7:0] OP_LOADI = 8'h30;

  localparam logic [3:0] REG_NONE = 4'hF;

  localparam logic [2:0] ST_RUN   = 3'd1;
  localparam logic [2:0] ST_STOP  = 3'd2;
  localparam logic [2:0] ST_BADAD = 3'd3;
  localparam logic [2:0] ST_BADOP = 3'd4;
endpackage

// File: rtl/mvp_imem.sv
module mvp_imem #(
  parameter int DEPTH = 64,
  parameter int WIN   = 10,
  parameter int PCW   = 64,
  parameter int AW    = 6
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  input  logic [PCW-1:0]        rd_addr,
  output logic [WIN-1:0][7:0]   win_byte,
  output logic [WIN-1:0]        win_ok
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar i = 0; i < WIN; i++) begin : g_win
    logic [PCW-1:0] a;
    assign a           = rd_addr + PCW'(i);
    assign win_ok[i]   = (a < PCW'(DEPTH)) && (a >= rd_addr);
    assign win_byte[i] = win_ok[i] ? mem[a[AW-1:0]] : 8'h00;
  end
endmodule

// File: rtl/mvp_regfile.sv
module mvp_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_id,
  output logic [XLEN-1:0] rd_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_id,
  input  logic [XLEN-1:0] wr_data
);
  logic [XLEN-1:0] regs [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_id == 4'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[r] <= '0;
      else if (hit) regs[r] <= wr_data;
    end
  end

  assign rd_data = (32'(rd_id) < NREGS) ? regs[rd_id] : '0;
endmodule

// File: rtl/mvp_decode.sv
module mvp_decode
  import mvp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WIN  = 2 + XLEN/8
) (
  input  logic [WIN-1:0][7:0] win_byte,
  input  logic [WIN-1:0]      win_ok,
  input  logic [XLEN-1:0]     rf_rdata,
  input  logic                fw_en,
  input  logic [3:0]          fw_id,
  input  logic [XLEN-1:0]     fw_data,
  output logic [3:0]          d_src,
  output logic [7:0]          d_op,
  output logic [XLEN-1:0]     d_valc,
  output logic [XLEN-1:0]     d_rval,
  output logic [3:0]          d_dst,
  output logic [2:0]          d_stat,
  output logic [3:0]          d_len
);
  localparam int IMM_BYTES = XLEN / 8;

  always_comb begin
    d_op   = OP_NOP;
    d_src  = REG_NONE;
    d_dst  = REG_NONE;
    d_valc = '0;
    d_stat = ST_RUN;
    d_len  = 4'd0;
    if (!win_ok[0]) begin
      d_stat = ST_BADAD;
    end else begin
      case (win_byte[0])
        OP_STOP: begin
          d_op   = OP_STOP;
          d_stat = ST_STOP;
        end
        OP_NOP: d_len = 4'd1;
        OP_COPY: begin
          if (!win_ok[1]) d_stat = ST_BADAD;
          else begin
            d_op  = OP_COPY;
            d_len = 4'd2;
            d_src = win_byte[1][7:4];
            d_dst = win_byte[1][3:0];
          end
        end
        OP_LOADI: begin
          if (!win_ok[WIN-1]) d_stat = ST_BADAD;
          else begin
            d_op  = OP_LOADI;
            d_len = 4'(WIN);
            d_dst = win_byte[1][3:0];
            for (int k = 0; k < IMM_BYTES; k++) d_valc[8*k +: 8] = win_byte[2+k];
          end
        end
        default: d_stat = ST_BADOP;
      endcase
    end
  end

  // Bypass: the value entering the register file this cycle wins over the stale read.
  assign d_rval = (fw_en && (fw_id == d_src)) ? fw_data : rf_rdata;
endmodule

// File: rtl/mvp_dw_reg.sv
module mvp_dw_reg
  import mvp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [7:0]      d_op,
  input  logic [XLEN-1:0] d_valc,
  input  logic [XLEN-1:0] d_rval,
  input  logic [3:0]      d_dst,
  input  logic [2:0]      d_stat,
  output logic [7:0]      w_op,
  output logic [XLEN-1:0] w_valc,
  output logic [XLEN-1:0] w_rval,
  output logic [3:0]      w_dst,
  output logic [2:0]      w_stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_op   <= OP_NOP;
      w_valc <= '0;
      w_rval <= '0;
      w_dst  <= REG_NONE;
      w_stat <= ST_RUN;
    end else if (en) begin
      w_op   <= d_op;
      w_valc <= d_valc;
      w_rval <= d_rval;
      w_dst  <= d_dst;
      w_stat <= d_stat;
    end
  end
endmodule

// File: rtl/mv_pipe2_core.sv
module mv_pipe2_core
  import mvp_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int IMEM_BYTES = 64,
  parameter int NREGS      = 15,
  localparam int IMEM_AW   = $clog2(IMEM_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [7:0]         imem_wdata,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_en,
  output logic [3:0]         wb_dst,
  output logic [XLEN-1:0]    wb_data,
  output logic [2:0]         stat_o,
  output logic               halted
);
  localparam int WIN = 2 + XLEN/8;

  // Reset: asserted asynchronously, released through two flops.
  logic rs_q1, rs_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  logic [XLEN-1:0]     pc_q, pc_d;
  logic                pc_en;
  logic [WIN-1:0][7:0] win_byte;
  logic [WIN-1:0]      win_ok;
  logic [3:0]          d_src, d_dst, d_len;
  logic [7:0]          d_op, w_op;
  logic [XLEN-1:0]     d_valc, d_rval, w_valc, w_rval, rf_rdata;
  logic [2:0]          d_stat, w_stat;
  logic [3:0]          w_dst;

  mvp_imem #(.DEPTH(IMEM_BYTES), .WIN(WIN), .PCW(XLEN), .AW(IMEM_AW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .rd_addr(pc_q), .win_byte(win_byte), .win_ok(win_ok)
  );

  mvp_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rs_q2), .rd_id(d_src), .rd_data(rf_rdata),
    .wr_en(wb_en), .wr_id(w_dst), .wr_data(wb_data)
  );

  mvp_decode #(.XLEN(XLEN), .WIN(WIN)) u_dec (
    .win_byte(win_byte), .win_ok(win_ok), .rf_rdata(rf_rdata),
    .fw_en(wb_en), .fw_id(w_dst), .fw_data(wb_data),
    .d_src(d_src), .d_op(d_op), .d_valc(d_valc), .d_rval(d_rval),
    .d_dst(d_dst), .d_stat(d_stat), .d_len(d_len)
  );

  mvp_dw_reg #(.XLEN(XLEN)) u_dw (
    .clk(clk), .rst_n(rs_q2), .en(!halted),
    .d_op(d_op), .d_valc(d_valc), .d_rval(d_rval), .d_dst(d_dst), .d_stat(d_stat),
    .w_op(w_op), .w_valc(w_valc), .w_rval(w_rval), .w_dst(w_dst), .w_stat(w_stat)
  );

  // Fetch next-state: advance only on a clean decode while running.
  always_comb begin
    pc_en = (d_stat == ST_RUN) && !halted;
    pc_d  = pc_q + XLEN'(d_len);
  end

  always_ff @(posedge clk or negedge rs_q2) begin
    if (!rs_q2)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // Writeback side.
  assign wb_en   = (w_dst != REG_NONE);
  assign wb_dst  = w_dst;
  assign wb_data = (w_op == OP_LOADI) ? w_valc : w_rval;
  assign stat_o  = w_stat;
  assign halted  = (w_stat != ST_RUN);
  assign pc_o    = pc_q;
endmodule

// File: rtl/mvp_checker.sv
module mvp_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc_o,
  input logic            wb_en,
  input logic [2:0]      stat_o,
  input logic            halted
);
  assert_stat_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o >= 3'd1) && (stat_o <= 3'd4));

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> (pc_o == $past(pc_o)) || (pc_o == $past(pc_o) + XLEN'(1)) ||
                (pc_o == $past(pc_o) + XLEN'(2)) || (pc_o == $past(pc_o) + XLEN'(10)));

  assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc_o));

  assert_no_write_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !wb_en);

  assert_stat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(stat_o)));
endmodule

bind mv_pipe2_core mvp_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .wb_en(wb_en), .stat_o(stat_o), .halted(halted)
);

// File: tb/mv_pipe2_core_bench.sv
`timescale 1ns/1ps
module mv_pipe2_core_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [7:0]  imem_wdata = '0;
  logic [63:0] pc_o, wb_data;
  logic        wb_en, halted;
  logic [3:0]  wb_dst;
  logic [2:0]  stat_o;

  always #2 clk = ~clk;

  mv_pipe2_core u_mv_pipe2_core (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .pc_o(pc_o), .wb_en(wb_en), .wb_dst(wb_dst),
    .wb_data(wb_data), .stat_o(stat_o), .halted(halted)
  );

  int checks = 0;
  int errors = 0;

  // Program image and builder
  logic [7:0] prog [DEPTH];
  int wp;

  // Reference model state
  logic [63:0] m_pc;
  logic [63:0] m_regs [16];
  int          m_wdst;
  logic [63:0] m_wval;
  int          m_wstat;

  // Observations from the ports
  logic [63:0] obs_regs [16];
  int          obs_writes;
  int          halt_cycle;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    prog[wp] = b;
    wp++;
  endtask

  task automatic put_loadi(input logic [3:0] rb, input logic [63:0] imm);
    put(8'h30);
    put({4'hF, rb});
    for (int k = 0; k < 8; k++) put(imm[8*k +: 8]);
  endtask

  task automatic put_copy(input logic [3:0] ra, input logic [3:0] rb);
    put(8'h20);
    put({ra, rb});
  endtask

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) prog[i] = 8'h00;
    wp = 0;
  endtask

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return (a < 64'(DEPTH)) ? prog[a[5:0]] : 8'h00;
  endfunction

  // One architectural step: retire the writeback slot, then decode at m_pc.
  task automatic model_step();
    int st, dst, len;
    logic [63:0] val;
    logic [7:0] op, b1;
    if (m_wstat != 1) return;
    if (m_wdst != 15) m_regs[m_wdst] = m_wval;
    st = 1; dst = 15; len = 0; val = '0;
    op = mbyte(m_pc);
    b1 = mbyte(m_pc + 1);
    if (m_pc >= 64'(DEPTH)) st = 3;
    else if (op == 8'h00) st = 2;
    else if (op == 8'h10) len = 1;
    else if (op == 8'h20) begin
      if (m_pc + 1 >= 64'(DEPTH)) st = 3;
      else begin
        len = 2;
        dst = int'(b1[3:0]);
        val = (b1[7:4] == 4'hF) ? 64'd0 : m_regs[b1[7:4]];
      end
    end else if (op == 8'h30) begin
      if (m_pc + 9 >= 64'(DEPTH)) st = 3;
      else begin
        len = 10;
        dst = int'(b1[3:0]);
        for (int k = 0; k < 8; k++) val[8*k +: 8] = mbyte(m_pc + 64'(2 + k));
      end
    end else st = 4;
    m_wdst  = dst;
    m_wval  = val;
    m_wstat = st;
    if (st == 1) m_pc = m_pc + 64'(len);
  endtask

  task automatic compare_model();
    bit exp_en;
    exp_en = (m_wdst != 15);
    check(pc_o == m_pc, "R6", "pc", pc_o, m_pc);
    check(wb_en == exp_en, "R10", "wb_en", 64'(wb_en), 64'(exp_en));
    if (exp_en && wb_en) begin
      check(wb_dst == 4'(m_wdst), "R2", "wb_dst", 64'(wb_dst), 64'(m_wdst));
      check(wb_data == m_wval, "R3", "wb_data", wb_data, m_wval);
    end
    check(stat_o == 3'(m_wstat), "R11", "stat", 64'(stat_o), 64'(m_wstat));
    check(halted == (m_wstat != 1), "R7", "halted", 64'(halted), 64'(m_wstat != 1));
  endtask

  task automatic run_prog();
    int rel_edges, active, after_halt;
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      imem_we    = 1'b1;
      imem_waddr = 6'(i);
      imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    m_pc = '0; m_wdst = 15; m_wval = '0; m_wstat = 1;
    for (int r = 0; r < 16; r++) begin
      m_regs[r] = '0;
      obs_regs[r] = '0;
    end
    obs_writes = 0;
    halt_cycle = -1;
    // R1: values held in reset
    check(pc_o == 64'd0 && stat_o == 3'd1 && !halted && !wb_en, "R1", "reset outputs",
          {pc_o[31:0], 24'd0, 1'b0, stat_o, 3'd0, halted}, 64'h10);
    rst_n = 1'b1;
    rel_edges = 0; active = 0; after_halt = 0;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk);
      rel_edges++;
      if (rel_edges >= 3) begin
        active++;
        model_step();
      end
      @(negedge clk);
      compare_model();
      if (rel_edges <= 2)
        check(pc_o == 64'd0 && !halted && stat_o == 3'd1, "R1", "sync release hold",
              pc_o, 64'd0);
      if (wb_en) begin
        obs_regs[wb_dst] = wb_data;
        obs_writes++;
      end
      if (halted && halt_cycle < 0) halt_cycle = active + 1;
      if (halted) begin
        after_halt++;
        if (after_halt > 3) break;
      end
    end
  endtask

  initial begin
    // Program A: dependent copy right behind a load
    clear_prog();
    put_loadi(4'h0, 64'd1);
    put_copy(4'h0, 4'h3);
    put(8'h00);
    run_prog();
    check(halt_cycle == 4, "R4", "cycles to halt", 64'(halt_cycle), 64'd4);
    check(obs_regs[0] == 64'd1, "R4", "reg0", obs_regs[0], 64'd1);
    check(obs_regs[3] == 64'd1, "R4", "reg3", obs_regs[3], 64'd1);
    check(stat_o == 3'd2, "R7", "stop status", 64'(stat_o), 64'd2);
    check(pc_o == 64'd12, "R7", "pc at stop", pc_o, 64'd12);

    // Program B: four moves then stop
    clear_prog();
    put_loadi(4'h0, 64'h162e);
    put_loadi(4'h1, 64'h22);
    put_copy(4'h0, 4'h2);
    put_copy(4'h1, 4'h0);
    put(8'h00);
    run_prog();
    check(halt_cycle == 6, "R5", "cycles to halt", 64'(halt_cycle), 64'd6);
    check(obs_regs[0] == 64'h22, "R5", "reg0", obs_regs[0], 64'h22);
    check(obs_regs[1] == 64'h22, "R5", "reg1", obs_regs[1], 64'h22);
    check(obs_regs[2] == 64'h162e, "R5", "reg2", obs_regs[2], 64'h162e);
    check(pc_o == 64'h18, "R5", "final pc", pc_o, 64'h18);

    // Program C: copy chain, zero source, null destination, bad opcode
    clear_prog();
    put(8'h10);
    put_loadi(4'h8, 64'h0123456789abcdef);
    put_copy(4'h8, 4'hE);
    put_copy(4'hE, 4'h1);
    put_loadi(4'h6, 64'hAA);
    put_copy(4'hF, 4'h6);
    put_loadi(4'hF, 64'h77);
    put(8'h55);
    put_loadi(4'h7, 64'h9);
    run_prog();
    check(obs_regs[1] == 64'h0123456789abcdef, "R2", "little-endian imm via chain",
          obs_regs[1], 64'h0123456789abcdef);
    check(obs_regs[6] == 64'd0, "R3", "source 0xF reads zero", obs_regs[6], 64'd0);
    check(obs_writes == 5, "R10", "write count", 64'(obs_writes), 64'd5);
    check(obs_regs[7] == 64'd0, "R8", "no write after bad opcode", obs_regs[7], 64'd0);
    check(stat_o == 3'd4, "R8", "bad opcode status", 64'(stat_o), 64'd4);
    check(pc_o == 64'd37, "R8", "pc at bad opcode", pc_o, 64'd37);

    // Program D: load straddling the end of the store
    clear_prog();
    for (int i = 0; i < 60; i++) put(8'h10);
    put(8'h30);
    put(8'hF2);
    run_prog();
    check(stat_o == 3'd3, "R9", "bad address status", 64'(stat_o), 64'd3);
    check(pc_o == 64'd60, "R9", "pc at straddling load", pc_o, 64'd60);
    check(halt_cycle == 62, "R9", "cycles to halt", 64'(halt_cycle), 64'd62);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired R7 actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule